// File: doc/BRIEF.md
# Receive FIFO Character-Timeout Detector

This block sits beside a serial receiver's FIFO and decides when received data has been left unread for too long. It counts oversampled baud ticks since the most recent activity on the FIFO. Activity means a character pushed in from the deserializer or a CPU read. Once four full character times pass with data still waiting, it raises a character-timeout interrupt request. The length of one character time comes from the programmed frame: start bit, data bits, optional parity and one or two stop bits. Because of this, the wait scales with both the baud rate and the frame format. For example, a 12-bit frame at 300 baud gives roughly 160 ms.

The block also keeps the receive data-ready status flag. The flag sets when a character lands in the FIFO and clears when the FIFO drains. The FIFO storage, the deserializer and the register decode live elsewhere. This block sees only single-cycle push and read strobes, the occupancy count and the configuration fields.

Top module: `rx_idle_timeout`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `timeout_irq`, `data_ready` and the idle timer by the following cycle.
- R2: `data_ready` is 1 in the cycle after any cycle with `push_evt` high.
- R3: With `fifo_count` equal to 0 and no push in the same cycle, `data_ready` is 0 in the following cycle.
- R4: The bits per character are 1 start + (5 + `wlen`) data + `parity_en` + (`two_stop` ? 2 : 1) stop, giving 7 to 12. The idle window is 4 × 16 × bits baud ticks.
- R5: Suppose the timer restarted at edge E, ticks arrive on every following cycle, the FIFO stays non-empty and both enables are high. Then `timeout_irq` is still 0 after the window's worth of further edges and is 1 one edge later.
- R6: A push before the window expires restarts the timer, so the interrupt comes one full window after that push.
- R7: A CPU read before the window expires restarts the timer in the same way.
- R8: While `timeout_irq` is high, a read clears it in the next cycle and restarts the timer. If data remains, the interrupt returns after another full window.
- R9: A push while `timeout_irq` is high (without a read) leaves `timeout_irq` high.
- R10: `timeout_irq` is 0 in the cycle after any cycle with `fifo_en` or `rx_ie` low. Disabling either control clears it, and reenabling does not clear the elapsed time.
- R11: The timer advances only on cycles with `baud_tick` high. Without ticks it holds its value, whatever the number of clock cycles.
- R12: With an empty FIFO (`fifo_count` = 0) the timer is held at zero and no timeout is raised.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | 16x-oversample baud enable, one cycle wide |
| push_evt | input | 1 | Character moved from shift register into the FIFO |
| read_evt | input | 1 | CPU read of one character from the FIFO |
| fifo_count | input | CNT_W (5) | Current FIFO occupancy |
| wlen | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Two stop bits programmed |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_ie | input | 1 | Receive interrupts enabled |
| timeout_irq | output | 1 | Character-timeout interrupt request |
| data_ready | output | 1 | Receive data-ready status flag |

## Verification
The timeout path is tried first over six frame formats, one for each total length from 7 to 12 bits. This separates a correct bits-per-character sum from one that drops parity or the second stop bit: the interrupt must stay low exactly one window's worth of ticks and rise on the next edge. Directed sequences then restart the timer by a late push and by a late read. This tells apart a timer cleared by either event from one cleared by only one of them. Stalled ticks, toggled enables, pushes during a pending interrupt and a drained FIFO separate true gating and holding from a free-running or self-clearing timer.

// File: rtl/rxto_pkg.sv
`timescale 1ns/1ps
package rxto_pkg;

  // Total frame length: start + data + parity + stop(s).
  function automatic int unsigned frame_bits(input logic [1:0] wlen,
                                             input logic parity_en,
                                             input logic two_stop);
    int unsigned data_bits;
    int unsigned stop_bits;
    data_bits = 32'd5 + 32'(wlen);
    stop_bits = two_stop ? 32'd2 : 32'd1;
    return 32'd1 + data_bits + 32'(parity_en) + stop_bits;
  endfunction

  // Idle window in baud ticks.
  function automatic int unsigned window_ticks(input int unsigned bits,
                                               input int unsigned ticks_per_bit,
                                               input int unsigned idle_chars);
    return bits * ticks_per_bit * idle_chars;
  endfunction

endpackage

// File: rtl/rxto_char_len.sv
`timescale 1ns/1ps
module rxto_char_len #(
  parameter int TICKS_PER_BIT = 16,
  parameter int IDLE_CHARS    = 4,
  parameter int TMR_W         = 10
) (
  input  logic [1:0]       wlen,
  input  logic             parity_en,
  input  logic             two_stop,
  output logic [TMR_W-1:0] limit
);
  int unsigned bits;

  always_comb begin
    bits  = rxto_pkg::frame_bits(wlen, parity_en, two_stop);
    limit = TMR_W'(rxto_pkg::window_ticks(bits, TICKS_PER_BIT, IDLE_CHARS));
  end
endmodule

// File: rtl/rxto_idle_timer.sv
`timescale 1ns/1ps
module rxto_idle_timer #(
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [TMR_W-1:0] limit,
  output logic [TMR_W-1:0] count,
  output logic             expired
);
  logic [TMR_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count_q <= '0;
    end else if (tick && (count_q < limit)) begin
      count_q <= count_q + TMR_W'(1);
    end
  end

  assign count   = count_q;
  assign expired = (count_q >= limit);
endmodule

// File: rtl/rxto_ready_flag.sv
`timescale 1ns/1ps
module rxto_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic empty,
  output logic ready
);
  logic ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
    end else if (push) begin
      ready_q <= 1'b1;
    end else if (empty) begin
      ready_q <= 1'b0;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/rx_idle_timeout.sv
`timescale 1ns/1ps
module rx_idle_timeout #(
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int IDLE_CHARS    = 4,
  localparam int CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_tick,
  input  logic             push_evt,
  input  logic             read_evt,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [1:0]       wlen,
  input  logic             parity_en,
  input  logic             two_stop,
  input  logic             fifo_en,
  input  logic             rx_ie,
  output logic             timeout_irq,
  output logic             data_ready
);
  localparam int MAX_BITS  = 12;
  localparam int LIMIT_MAX = MAX_BITS * TICKS_PER_BIT * IDLE_CHARS;
  localparam int TMR_W     = $clog2(LIMIT_MAX + 1);

  // Named internal events, also seen by the bound checker.
  logic             fifo_empty;
  logic             tmr_restart;
  logic             tmr_expired;
  logic [TMR_W-1:0] tmr_limit;
  logic [TMR_W-1:0] tmr_count;
  logic             irq_arm;
  logic             irq_drop;
  logic             irq_q;

  assign fifo_empty  = (fifo_count == '0);
  assign tmr_restart = push_evt | read_evt | fifo_empty;

  rxto_char_len #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .IDLE_CHARS    (IDLE_CHARS),
    .TMR_W         (TMR_W)
  ) u_len (
    .wlen      (wlen),
    .parity_en (parity_en),
    .two_stop  (two_stop),
    .limit     (tmr_limit)
  );

  rxto_idle_timer #(
    .TMR_W (TMR_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick),
    .restart (tmr_restart),
    .limit   (tmr_limit),
    .count   (tmr_count),
    .expired (tmr_expired)
  );

  rxto_ready_flag u_rdy (
    .clk   (clk),
    .rst   (rst),
    .push  (push_evt),
    .empty (fifo_empty),
    .ready (data_ready)
  );

  assign irq_drop = rst | ~fifo_en | ~rx_ie | read_evt;
  assign irq_arm  = tmr_expired & ~fifo_empty & fifo_en & rx_ie;

  always_ff @(posedge clk) begin
    if (irq_drop) begin
      irq_q <= 1'b0;
    end else if (irq_arm) begin
      irq_q <= 1'b1;
    end
  end

  assign timeout_irq = irq_q;
endmodule

// File: rtl/rx_idle_timeout_chk.sv
`timescale 1ns/1ps
module rx_idle_timeout_chk #(
  parameter int CNT_W = 5,
  parameter int TMR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             baud_tick,
  input logic             push_evt,
  input logic             read_evt,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_en,
  input logic             rx_ie,
  input logic             timeout_irq,
  input logic             data_ready,
  input logic             tmr_restart,
  input logic             tmr_expired,
  input logic [TMR_W-1:0] tmr_count
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!timeout_irq && !data_ready && tmr_count == '0));

  p_ready_set_r2: assert property (@(posedge clk) disable iff (rst)
    push_evt |=> data_ready);

  p_ready_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0 && !push_evt) |=> !data_ready);

  p_rise_after_window_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_irq) |-> $past(tmr_expired));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    read_evt |=> !timeout_irq);

  p_push_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (timeout_irq && push_evt && !read_evt && fifo_en && rx_ie) |=> timeout_irq);

  p_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en || !rx_ie) |=> !timeout_irq);

  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (!baud_tick && !tmr_restart) |=> $stable(tmr_count));

  p_empty_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0) |=> (tmr_count == '0));
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(
  .CNT_W (CNT_W),
  .TMR_W (TMR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .baud_tick   (baud_tick),
  .push_evt    (push_evt),
  .read_evt    (read_evt),
  .fifo_count  (fifo_count),
  .fifo_en     (fifo_en),
  .rx_ie       (rx_ie),
  .timeout_irq (timeout_irq),
  .data_ready  (data_ready),
  .tmr_restart (tmr_restart),
  .tmr_expired (tmr_expired),
  .tmr_count   (tmr_count)
);

// File: tb/test_rx_idle_timeout.sv
`timescale 1ns/1ps
module test_rx_idle_timeout;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b1;
  logic       push_evt = 1'b0;
  logic       read_evt = 1'b0;
  logic [4:0] fifo_count = '0;
  logic [1:0] wlen = 2'd0;
  logic       parity_en = 1'b0;
  logic       two_stop = 1'b0;
  logic       fifo_en = 1'b1;
  logic       rx_ie = 1'b1;
  logic       timeout_irq;
  logic       data_ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rx_idle_timeout i_rx_idle_timeout (
    .clk         (clk),
    .rst         (rst),
    .baud_tick   (baud_tick),
    .push_evt    (push_evt),
    .read_evt    (read_evt),
    .fifo_count  (fifo_count),
    .wlen        (wlen),
    .parity_en   (parity_en),
    .two_stop    (two_stop),
    .fifo_en     (fifo_en),
    .rx_ie       (rx_ie),
    .timeout_irq (timeout_irq),
    .data_ready  (data_ready)
  );

  // {wlen[1:0], parity_en, two_stop}: frames of 7,8,10,11,12,9 bits
  localparam logic [3:0] VEC [6] = '{4'b0000, 4'b0100, 4'b1010,
                                     4'b1101, 4'b1111, 4'b0011};

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected window length from the R4 formula, written independently.
  function automatic int exp_window(input logic [1:0] w, input logic p, input logic s);
    return 64 * (7 + int'(w) + int'(p) + int'(s));
  endfunction

  task automatic pulse_push(input logic [4:0] cnt);
    push_evt = 1'b1; fifo_count = cnt; step(); push_evt = 1'b0;
  endtask

  task automatic pulse_read(input logic [4:0] cnt);
    read_evt = 1'b1; step(); read_evt = 1'b0; fifo_count = cnt;
  endtask

  initial begin
    int win;
    step(2);
    rst = 1'b0;
    check("R1 reset irq", timeout_irq, 1'b0);
    check("R1 reset ready", data_ready, 1'b0);

    // Vector walk over frame formats (R4, R5).
    for (int v = 0; v < 6; v++) begin
      rst = 1'b1; step(); rst = 1'b0;
      {wlen, parity_en, two_stop} = VEC[v];
      win = exp_window(VEC[v][3:2], VEC[v][1], VEC[v][0]);
      pulse_push(5'd1);
      step(win);
      check("R4 window not yet", timeout_irq, 1'b0);
      step();
      check("R5 timeout rises", timeout_irq, 1'b1);
    end

    // Directed tests, 7-bit frame.
    rst = 1'b1; fifo_count = '0; step(); rst = 1'b0;
    {wlen, parity_en, two_stop} = 4'b0000;
    win = exp_window(2'd0, 1'b0, 1'b0);
    check("R1 ready after reset", data_ready, 1'b0);
    pulse_push(5'd1);
    check("R2 ready sets", data_ready, 1'b1);
    step(win - 10);
    pulse_push(5'd2);
    step(win);
    check("R6 push restarts", timeout_irq, 1'b0);
    step();
    check("R6 fires after restart", timeout_irq, 1'b1);

    pulse_push(5'd3);
    check("R9 push keeps irq", timeout_irq, 1'b1);

    pulse_read(5'd2);
    check("R8 read clears", timeout_irq, 1'b0);
    step(win);
    check("R8 restarted window", timeout_irq, 1'b0);
    step();
    check("R8 fires again", timeout_irq, 1'b1);

    pulse_read(5'd1);
    step(win - 5);
    pulse_read(5'd1);
    step(win);
    check("R7 read restarts", timeout_irq, 1'b0);
    step();
    check("R7 fires after read", timeout_irq, 1'b1);

    fifo_en = 1'b0; step();
    check("R10 fifo disable clears", timeout_irq, 1'b0);
    step(win + 2);
    check("R10 stays off", timeout_irq, 1'b0);
    fifo_en = 1'b1; rx_ie = 1'b0; step(3);
    check("R10 rx_ie gates", timeout_irq, 1'b0);
    rx_ie = 1'b1; step();
    check("R10 reenable keeps elapsed", timeout_irq, 1'b1);

    pulse_read(5'd1);
    baud_tick = 1'b0;
    step(2000);
    check("R11 no ticks no irq", timeout_irq, 1'b0);
    baud_tick = 1'b1;
    step(win);
    check("R11 window in ticks", timeout_irq, 1'b0);
    step();
    check("R11 fires on ticks", timeout_irq, 1'b1);

    rst = 1'b1; step(); rst = 1'b0;
    check("R1 mid reset irq", timeout_irq, 1'b0);
    check("R1 mid reset ready", data_ready, 1'b1 ^ 1'b1);

    pulse_push(5'd1);
    pulse_read(5'd0);
    step();
    check("R3 ready clears on empty", data_ready, 1'b0);
    step(win + 5);
    check("R12 empty no irq", timeout_irq, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule